// File: doc/BRIEF.md
# Memory-Range CRC32 Engine

This block computes a CRC32 checksum over a word-aligned stretch of memory. Software loads a start address, a byte count and a seed, then issues a start command. The engine walks the range one 32-bit word at a time over a simple read bus that has one request outstanding. It folds each returned word into a running checksum built on the reflected polynomial 0xEDB88320. When the walk ends, the raw checksum stays in the data register without its final inversion. A later calculation can use it directly as a seed, so several regions can share one checksum. Software inverts it to get the conventional CRC32 value.

Three flags report the outcome: completion, a bus error and a functional failure. While the device is locked, a start ignores the values software wrote. It uses a fixed base, size and seed instead, and these describe the whole array. A disable command cancels any run and returns every register to its reset value. After that, only an enable command makes the block accept writes and starts again.

Top module: `crc_range_engine`

## Requirements
- R1: Each accepted word updates the checksum with the reflected polynomial 0xEDB88320, taking bit 0 of the word first. The data register keeps the raw, non-inverted result. A seed of 0xFFFFFFFF over one word of zero leaves 0xDEBB20E3.
- R2: A run reads the words at the start address, then at that address plus 4, and so on, one request at a time. After each word, the address register rises by 4 and the length register falls by 4. When the run completes, the address points just past the range and the length is 0.
- R3: The data register supplies the seed. Seeding a second run with the result of a first run gives the same value as a single run over both ranges joined together.
- R4: If protect_i is high when a start is accepted, the run uses base P_BASE, length P_SIZE and seed P_SEED. The user-written address, length and seed are ignored.
- R5: A start is accepted only while the block is enabled and no run is in progress. An accepted start clears all three flags. A start while the block is disabled issues no read.
- R6: cmd_dis resets every register and flag to 0 and disables the block, cancelling any run. While the block is disabled, register writes and starts have no effect. cmd_en enables the block again. Reset leaves the block disabled.
- R7: When the last word of a run is accepted, done_o rises on the next clock and busy_o and rd_req fall.
- R8: A read answered with rd_err ends the run. It sets bus_err_o and done_o, issues no further reads, and leaves the address, length and data registers unchanged by that word.
- R9: A start with a length of 0 sets done_o on the next clock, issues no read and leaves the seed unchanged.
- R10: A start whose effective address or length has either of bits 1:0 set sets fail_o and done_o on the next clock and issues no read.
- R11: Writes to the address, length and data registers are ignored while a run is in progress, and also in the cycle in which a start is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_en | input | 1 | Enable command pulse |
| cmd_dis | input | 1 | Disable/cancel command pulse |
| cmd_start | input | 1 | Start command pulse |
| protect_i | input | 1 | Device locked; forces whole-array range and seed |
| addr_we | input | 1 | Address register write strobe |
| len_we | input | 1 | Length register write strobe |
| data_we | input | 1 | Data (seed) register write strobe |
| wr_value | input | AW | Value written by any strobe |
| rd_req | output | 1 | Read request |
| rd_addr | output | AW | Byte address of requested word |
| rd_valid | input | 1 | Read response present this cycle |
| rd_err | input | 1 | Read response is an error |
| rd_data | input | 32 | Read data |
| addr_o | output | AW | Address register |
| len_o | output | AW | Length register (bytes) |
| data_o | output | 32 | Data register (seed / raw result) |
| busy_o | output | 1 | Run in progress |
| enabled_o | output | 1 | Block enabled |
| done_o | output | 1 | Completion flag |
| bus_err_o | output | 1 | Bus error flag |
| fail_o | output | 1 | Functional failure flag |

## Verification
The bench targets a known single-word checksum. A design that shifted the wrong way or inverted the result would miss 0xDEBB20E3. It also chains two half-range runs against one whole run, which exposes a seed that the engine reloads instead of reading from the data register. Stalled responses, an error in the middle of a range, zero and misaligned lengths, and a locked start check for three faults: reads issued after a fault, flags that never rise, and user values that leak into a protected run. A cancel during a run, followed by a start while disabled, checks that disabling really resets the block and that it refuses commands until it is enabled again.

// File: rtl/crc_pkg.sv
package crc_pkg;
    localparam logic [31:0] CRC_POLY = 32'hEDB88320;

    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic b);
        logic fb;
        fb = c[0] ^ b;
        return (c >> 1) ^ (fb ? CRC_POLY : 32'h0);
    endfunction
endpackage

// File: rtl/crc_fold.sv
module crc_fold #(
    parameter int W = 32
) (
    input  logic [31:0]  crc_in,
    input  logic [W-1:0] word,
    output logic [31:0]  crc_out
);
    logic [31:0] chain [0:W];

    assign chain[0] = crc_in;
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign chain[i+1] = crc_pkg::crc_step(chain[i], word[i]);
    end
    assign crc_out = chain[W];
endmodule

// File: rtl/crc_range_check.sv
module crc_range_check #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] len,
    output logic          misaligned,
    output logic          empty
);
    assign misaligned = (addr[1:0] != 2'b00) || (len[1:0] != 2'b00);
    assign empty      = (len == '0);
endmodule

// File: rtl/crc_range_engine.sv
module crc_range_engine #(
    parameter int          AW     = 32,
    parameter logic [31:0] P_BASE = 32'h0000_0000,
    parameter logic [31:0] P_SIZE = 32'h0000_0040,
    parameter logic [31:0] P_SEED = 32'hFFFF_FFFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_en,
    input  logic          cmd_dis,
    input  logic          cmd_start,
    input  logic          protect_i,
    input  logic          addr_we,
    input  logic          len_we,
    input  logic          data_we,
    input  logic [AW-1:0] wr_value,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_valid,
    input  logic          rd_err,
    input  logic [31:0]   rd_data,
    output logic [AW-1:0] addr_o,
    output logic [AW-1:0] len_o,
    output logic [31:0]   data_o,
    output logic          busy_o,
    output logic          enabled_o,
    output logic          done_o,
    output logic          bus_err_o,
    output logic          fail_o
);
    localparam logic [AW-1:0] STEP = AW'(4);

    typedef struct packed {
        logic          en;
        logic          busy;
        logic [AW-1:0] addr;
        logic [AW-1:0] len;
        logic [31:0]   data;
        logic          done;
        logic          berr;
        logic          fail;
    } eng_t;

    eng_t st_d, st_q;

    logic          start_ok, word_ok;
    logic [AW-1:0] eff_addr, eff_len;
    logic [31:0]   eff_seed, crc_next;
    logic          bad_range, zero_len;

    assign start_ok = st_q.en && !st_q.busy && cmd_start;
    assign word_ok  = st_q.busy && rd_valid;
    assign eff_addr = protect_i ? AW'(P_BASE) : st_q.addr;
    assign eff_len  = protect_i ? AW'(P_SIZE) : st_q.len;
    assign eff_seed = protect_i ? P_SEED : st_q.data;

    crc_range_check #(.AW(AW)) u_check (
        .addr(eff_addr), .len(eff_len),
        .misaligned(bad_range), .empty(zero_len)
    );

    crc_fold #(.W(32)) u_fold (
        .crc_in(st_q.data), .word(rd_data), .crc_out(crc_next)
    );

    always_comb begin
        st_d = st_q;
        if (st_q.en && !st_q.busy && !cmd_start) begin
            if (addr_we) st_d.addr = wr_value;
            if (len_we)  st_d.len  = wr_value;
            if (data_we) st_d.data = 32'(wr_value);
        end
        if (start_ok) begin
            st_d.addr = eff_addr;
            st_d.len  = eff_len;
            st_d.data = eff_seed;
            st_d.done = 1'b0;
            st_d.berr = 1'b0;
            st_d.fail = 1'b0;
            if (bad_range) begin
                st_d.fail = 1'b1;
                st_d.done = 1'b1;
            end else if (zero_len) begin
                st_d.done = 1'b1;
            end else begin
                st_d.busy = 1'b1;
            end
        end
        if (word_ok) begin
            if (rd_err) begin
                st_d.busy = 1'b0;
                st_d.berr = 1'b1;
                st_d.done = 1'b1;
            end else begin
                st_d.data = crc_next;
                st_d.addr = st_q.addr + STEP;
                st_d.len  = st_q.len - STEP;
                if (st_q.len == STEP) begin
                    st_d.busy = 1'b0;
                    st_d.done = 1'b1;
                end
            end
        end
        if (cmd_en && !st_q.en) st_d.en = 1'b1;
        if (cmd_dis) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_req    = st_q.busy;
    assign rd_addr   = st_q.addr;
    assign addr_o    = st_q.addr;
    assign len_o     = st_q.len;
    assign data_o    = st_q.data;
    assign busy_o    = st_q.busy;
    assign enabled_o = st_q.en;
    assign done_o    = st_q.done;
    assign bus_err_o = st_q.berr;
    assign fail_o    = st_q.fail;

    assert_fetch_aligned_R10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> (st_q.addr[1:0] == 2'b00 && st_q.len[1:0] == 2'b00 && st_q.len != '0));

    assert_cancel_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_dis |=> (!enabled_o && !busy_o && !done_o && addr_o == '0));

    assert_bus_err_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (word_ok && rd_err && !cmd_dis) |=> (bus_err_o && done_o && !rd_req));

    assert_word_advances_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (word_ok && !rd_err && !cmd_dis) |=> (addr_o == $past(addr_o) + STEP));

    assert_protect_override_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start_ok && protect_i && !cmd_dis) |=> (addr_o == AW'(P_BASE) && data_o == P_SEED));

    assert_fail_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_ok && bad_range && !cmd_dis) |=> (fail_o && done_o && !rd_req));

    assert_done_on_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (word_ok && !rd_err && !cmd_dis && len_o == STEP) |=> (done_o && !busy_o));
endmodule

// File: tb/tb_crc_range_engine.sv
module tb_crc_range_engine;
    localparam int AW = 32;
    localparam logic [31:0] P_BASE = 32'h0000_0000;
    localparam logic [31:0] P_SIZE = 32'h0000_0040;
    localparam logic [31:0] P_SEED = 32'hFFFF_FFFF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_en = 0, cmd_dis = 0, cmd_start = 0, protect_i = 0;
    logic addr_we = 0, len_we = 0, data_we = 0;
    logic [31:0] wr_value = '0;
    logic rd_req, rd_valid, rd_err;
    logic [31:0] rd_addr, rd_data;
    logic [31:0] addr_o, len_o, data_o;
    logic busy_o, enabled_o, done_o, bus_err_o, fail_o;

    logic stall_mode = 0, gate = 1;
    logic err_armed = 0;
    logic [31:0] err_addr = '0;
    int n_checks = 0, n_fail = 0, cyc = 0;

    always #5 clk = ~clk;

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        if (a >= 32'h100 && a < 32'h110) return 32'h0;
        return {a[15:0] ^ 16'h5A3C, ~a[15:0]} + 32'h0101_0101;
    endfunction

    function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [31:0] w);
        logic [31:0] r;
        r = c;
        for (int k = 0; k < 4; k++) begin
            r = r ^ {24'h0, w[8*k +: 8]};
            for (int j = 0; j < 8; j++)
                r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
        end
        return r;
    endfunction

    assign rd_valid = rd_req & gate;
    assign rd_err   = rd_req & err_armed & (rd_addr == err_addr);
    assign rd_data  = mem_word(rd_addr);

    crc_range_engine #(.AW(AW), .P_BASE(P_BASE), .P_SIZE(P_SIZE), .P_SEED(P_SEED)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_en(cmd_en), .cmd_dis(cmd_dis), .cmd_start(cmd_start),
        .protect_i(protect_i), .addr_we(addr_we), .len_we(len_we), .data_we(data_we),
        .wr_value(wr_value), .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid),
        .rd_err(rd_err), .rd_data(rd_data), .addr_o(addr_o), .len_o(len_o), .data_o(data_o),
        .busy_o(busy_o), .enabled_o(enabled_o), .done_o(done_o), .bus_err_o(bus_err_o),
        .fail_o(fail_o)
    );

    // behavioural reference model
    logic m_en = 0, m_busy = 0, m_done = 0, m_berr = 0, m_fail = 0;
    logic [31:0] m_addr = 0, m_len = 0, m_data = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_en = 0; m_busy = 0; m_done = 0; m_berr = 0; m_fail = 0;
            m_addr = 0; m_len = 0; m_data = 0;
        end else if (cmd_dis) begin
            m_en = 0; m_busy = 0; m_done = 0; m_berr = 0; m_fail = 0;
            m_addr = 0; m_len = 0; m_data = 0;
        end else begin
            logic was_en;
            was_en = m_en;
            if (m_busy && gate) begin
                if (err_armed && m_addr == err_addr) begin
                    m_busy = 0; m_berr = 1; m_done = 1;
                end else begin
                    m_data = ref_crc(m_data, mem_word(m_addr));
                    m_addr += 4; m_len -= 4;
                    if (m_len == 0) begin m_busy = 0; m_done = 1; end
                end
            end else if (was_en && !m_busy && cmd_start) begin
                if (protect_i) begin m_addr = P_BASE; m_len = P_SIZE; m_data = P_SEED; end
                m_done = 0; m_berr = 0; m_fail = 0;
                if (m_addr[1:0] != 0 || m_len[1:0] != 0) begin m_fail = 1; m_done = 1; end
                else if (m_len == 0) m_done = 1;
                else m_busy = 1;
            end else if (was_en && !m_busy) begin
                if (addr_we) m_addr = wr_value;
                if (len_we)  m_len  = wr_value;
                if (data_we) m_data = wr_value;
            end
            if (cmd_en) m_en = 1;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        gate <= stall_mode ? cyc[0] : 1'b1;
        if (rst_n) begin
            check("R1 model data",  data_o, m_data);
            check("R2 model addr",  addr_o, m_addr);
            check("R2 model len",   len_o, m_len);
            check("R7 model flags", {27'h0, enabled_o, busy_o, done_o, bus_err_o, fail_o},
                  {27'h0, m_en, m_busy, m_done, m_berr, m_fail});
        end
        if (cyc > 100000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<100000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    task automatic pulse_en();  @(negedge clk); cmd_en = 1;  @(negedge clk); cmd_en = 0;  endtask
    task automatic pulse_dis(); @(negedge clk); cmd_dis = 1; @(negedge clk); cmd_dis = 0; endtask
    task automatic start();     @(negedge clk); cmd_start = 1; @(negedge clk); cmd_start = 0; endtask
    task automatic wr(input int which, input logic [31:0] v);
        @(negedge clk);
        wr_value = v;
        addr_we = (which == 0); len_we = (which == 1); data_we = (which == 2);
        @(negedge clk);
        addr_we = 0; len_we = 0; data_we = 0;
    endtask
    task automatic setup(input logic [31:0] a, input logic [31:0] l, input logic [31:0] s);
        wr(0, a); wr(1, l); wr(2, s);
    endtask
    task automatic wait_done();
        int t = 0;
        while (!done_o && t < 2000) begin @(negedge clk); t++; end
    endtask

    logic [31:0] whole, part;

    initial begin
        repeat (3) @(negedge clk);
        check("R6 reset enabled", {31'h0, enabled_o}, 32'h0);
        check("R6 reset data", data_o, 32'h0);
        rst_n = 1;
        wr(0, 32'h123);
        @(negedge clk);
        check("R6 write ignored while disabled", addr_o, 32'h0);
        pulse_en();
        check("R6 enabled", {31'h0, enabled_o}, 32'h1);

        setup(32'h100, 4, 32'hFFFF_FFFF); start(); wait_done(); @(negedge clk);
        check("R1 zero word raw", data_o, 32'hDEBB20E3);

        stall_mode = 1;
        setup(32'h200, 32'h20, 32'hFFFF_FFFF); start();
        @(negedge clk); wr(0, 32'h0BAD_0000);
        wait_done(); @(negedge clk);
        check("R2 end addr", addr_o, 32'h220);
        check("R11 busy write ignored len", len_o, 32'h0);
        stall_mode = 0;

        setup(32'h300, 16, 32'hFFFF_FFFF); start(); wait_done(); whole = data_o;
        setup(32'h300, 8, 32'hFFFF_FFFF); start(); wait_done();
        wr(0, 32'h308); wr(1, 8); start(); wait_done(); @(negedge clk); part = data_o;
        check("R3 chained equals whole", part, whole);

        setup(32'h400, 0, 32'h1234_5678); start();
        check("R9 zero length done", {31'h0, done_o}, 32'h1);
        check("R9 seed kept", data_o, 32'h1234_5678);
        check("R9 no read", {31'h0, rd_req}, 32'h0);

        setup(32'h402, 8, 32'h1); start();
        check("R10 misaligned addr fail", {30'h0, fail_o, rd_req}, 32'h2);
        setup(32'h400, 6, 32'h1); start();
        check("R10 misaligned len fail", {30'h0, fail_o, done_o}, 32'h3);

        err_armed = 1; err_addr = 32'h410;
        setup(32'h400, 32'h20, 32'hFFFF_FFFF); start(); wait_done(); @(negedge clk);
        check("R8 bus error flags", {29'h0, bus_err_o, done_o, rd_req}, 32'h6);
        check("R8 addr held", addr_o, 32'h410);
        err_armed = 0;
        start();
        check("R5 start clears flags", {29'h0, bus_err_o, done_o, busy_o}, 32'h1);
        wait_done();

        protect_i = 1;
        setup(32'h500, 8, 32'h0); start();
        check("R4 forced base", addr_o, P_BASE);
        check("R4 forced len", len_o, P_SIZE);
        protect_i = 0;
        wait_done(); @(negedge clk);
        check("R4 end addr", addr_o, P_BASE + P_SIZE);

        setup(32'h200, 32'h20, 32'hFFFF_FFFF); start();
        @(negedge clk);
        pulse_dis();
        check("R6 cancel", {30'h0, busy_o, enabled_o}, 32'h0);
        start(); @(negedge clk);
        check("R5 start while disabled", {31'h0, rd_req}, 32'h0);
        pulse_en();
        setup(32'h100, 4, 32'hFFFF_FFFF); start(); wait_done(); @(negedge clk);
        check("R7 restart done", {31'h0, done_o}, 32'h1);
        check("R1 restart result", data_o, 32'hDEBB20E3);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule